// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the stream of retiring instructions and compares the byte address of each one against a small set of programmable breakpoint channels. Each channel holds a base address, a per-bit don't-care mask, an optional address-space identifier and a control word. When an enabled channel matches a retiring instruction, the unit raises a one-cycle debug-break request, a per-channel trigger pulse, or both, depending on the channel's two enables. It also records the hit in a sticky per-channel status bit.

Software programs the channels and reads or clears the status through a small register bus with a write strobe, a word address and a registered read port. The unit evaluates nothing while the core runs in debug mode, and nothing for instructions marked as speculative. Faulting addresses are still compared, so a break can land on a jump target that would raise an address error.

Register map (word address `bus_addr[5:0]`). When `bus_addr[5]` is 0, `bus_addr[4:2]` selects the channel and `bus_addr[1:0]` selects the field: 0 is the base address, 1 the mask, 2 the identifier and 3 the control word. Control bit 0 enables the break request, bit 1 enables the trigger and bit 2 requires an identifier match. Address 0x20 is the status word: bit n belongs to channel n, and writing 1 clears the bit. Address 0x21 reads the capability word: bits [3:0] hold the channel count and bit 4 the identifier-support flag.

Top module: `ibrk_unit`

## Requirements
- R1: While `dbg_mode` is 1 at a retire, no channel matches: `brk_req`, `trig` and the status bits stay unchanged by that instruction.
- R2: A retire with `spec` at 1 is never evaluated and produces no break, trigger or status change.
- R3: One cycle after a retire that matches a channel whose control bit 0 is set, `brk_req` is 1 for one cycle. `brk_req` is the OR over all such channels.
- R4: One cycle after a retire that matches a channel whose control bit 1 is set, `trig[n]` is 1 for one cycle. Channels without bit 1 set keep their trigger bit at 0.
- R5: The full byte address of the instruction is compared. Address bits whose mask bit is 1 are ignored, and a channel matches when every unmasked bit equals its base address bit.
- R6: With identifier support present and control bit 2 set, the channel also requires `cur_id` to equal its identifier register. Without support, the identifier register reads 0 and bit 2 has no effect.
- R7: Each status bit is set by a hit on its channel and stays set until software writes 1 to it at address 0x20. A hit in the same cycle as the clearing write leaves the bit set.
- R8: When several enabled channels match the same retire, every one of their status and trigger bits is set together.
- R9: Every register reads back its last written value on `bus_rdata` one cycle after `bus_addr` is presented. Writes to a channel index at or above the channel count have no effect. The capability word at 0x21 reports the channel count and the support flag.
- R10: With `ret_valid` at 0, or for a channel whose control bits 0 and 1 are both clear, nothing is evaluated and no status bit is set.
- R11: After reset, `brk_req`, `trig` and all status bits are 0, and every channel register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Lowest byte address of the retiring instruction |
| cur_id | input | IDW | Current address-space identifier |
| dbg_mode | input | 1 | Core is in debug mode |
| spec | input | 1 | Retiring instruction is speculative |
| brk_req | output | 1 | Registered debug-break request |
| trig | output | NCH | Registered per-channel trigger pulses |
| hit_sts | output | NCH | Sticky per-channel hit status |

## Verification
The bench builds two instances on one shared bus. The first has three channels, 32-bit addresses, a 4-bit identifier and identifier support. The second has one channel with no identifier support. Because the identifier is only 4 bits wide, every identifier value can be swept against a channel. With a 4-bit mask, a 64-address sweep covers both sides of the masked window, and the expected match is worked out arithmetically for every address. With three channels, simultaneous hits, a channel that has only a trigger enable and a channel with no enables can all be present at once. The second instance shows the identifier register reading 0 and the identifier-use bit being ignored.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int FLD_ADDR = 0;
  localparam int FLD_MASK = 1;
  localparam int FLD_ID   = 2;
  localparam int FLD_CTRL = 3;
  localparam int CB_BRK   = 0;
  localparam int CB_TRG   = 1;
  localparam int CB_USEID = 2;
  localparam int CTRL_W   = 3;
  localparam logic [5:0] A_STATUS = 6'h20;
  localparam logic [5:0] A_CAP    = 6'h21;
endpackage

// File: rtl/ibrk_cmp.sv
module ibrk_cmp #(
  parameter int AW    = 32,
  parameter int IDW   = 8,
  parameter bit IDSUP = 1'b1
) (
  input  logic [AW-1:0]  pc,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  mask,
  input  logic [IDW-1:0] id_now,
  input  logic [IDW-1:0] id_ch,
  input  logic           use_id,
  output logic           match
);
  logic addr_ok, id_ok;
  assign addr_ok = &((pc ~^ base) | mask);
  generate
    if (IDSUP) begin : g_id
      assign id_ok = !use_id || (id_now == id_ch);
    end else begin : g_noid
      logic unused_id;
      assign unused_id = ^{id_now, id_ch, use_id};
      assign id_ok = 1'b1;
    end
  endgenerate
  assign match = addr_ok && id_ok;
endmodule

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int IDW   = 8,
  parameter bit IDSUP = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic [5:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NCH-1:0]             hit,
  output logic [NCH-1:0][AW-1:0]     ch_base,
  output logic [NCH-1:0][AW-1:0]     ch_mask,
  output logic [NCH-1:0][IDW-1:0]    ch_id,
  output logic [NCH-1:0][CTRL_W-1:0] ch_ctrl,
  output logic [NCH-1:0]             sts
);
  logic       is_ch, sts_wr;
  logic [2:0] sel;
  logic [1:0] fld;
  assign is_ch  = !bus_addr[5];
  assign sel    = bus_addr[4:2];
  assign fld    = bus_addr[1:0];
  assign sts_wr = bus_we && (bus_addr == A_STATUS);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c;
    assign wr_c = bus_we && is_ch && (int'(sel) == c);
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_base[c] <= '0;
        ch_mask[c] <= '0;
        ch_ctrl[c] <= '0;
      end else if (wr_c) begin
        if (fld == 2'(FLD_ADDR)) ch_base[c] <= bus_wdata[AW-1:0];
        if (fld == 2'(FLD_MASK)) ch_mask[c] <= bus_wdata[AW-1:0];
        if (fld == 2'(FLD_CTRL)) ch_ctrl[c] <= bus_wdata[CTRL_W-1:0];
      end
    end
    if (IDSUP) begin : g_idr
      always_ff @(posedge clk) begin
        if (rst) ch_id[c] <= '0;
        else if (wr_c && fld == 2'(FLD_ID)) ch_id[c] <= bus_wdata[IDW-1:0];
      end
    end else begin : g_noidr
      assign ch_id[c] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sts <= '0;
    else     sts <= (sts & ~(sts_wr ? bus_wdata[NCH-1:0] : '0)) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == A_STATUS) bus_rdata <= 32'(sts);
      if (bus_addr == A_CAP)    bus_rdata <= {27'd0, IDSUP, 4'(NCH)};
      for (int c = 0; c < NCH; c++) begin
        if (is_ch && int'(sel) == c) begin
          case (fld)
            2'(FLD_ADDR): bus_rdata <= 32'(ch_base[c]);
            2'(FLD_MASK): bus_rdata <= 32'(ch_mask[c]);
            2'(FLD_ID):   bus_rdata <= 32'(ch_id[c]);
            default:      bus_rdata <= 32'(ch_ctrl[c]);
          endcase
        end
      end
    end
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts))); // R7
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
    hit != '0 |=> ((sts & $past(hit)) == $past(hit))); // R8
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int IDW   = 8,
  parameter bit IDSUP = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [5:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           ret_valid,
  input  logic [AW-1:0]  ret_pc,
  input  logic [IDW-1:0] cur_id,
  input  logic           dbg_mode,
  input  logic           spec,
  output logic           brk_req,
  output logic [NCH-1:0] trig,
  output logic [NCH-1:0] hit_sts
);
  logic [NCH-1:0][AW-1:0]     ch_base, ch_mask;
  logic [NCH-1:0][IDW-1:0]    ch_id;
  logic [NCH-1:0][CTRL_W-1:0] ch_ctrl;
  logic [NCH-1:0]             cmp_hit, hit, be, te;
  logic                       eval;

  assign eval = ret_valid && !dbg_mode && !spec;

  ibrk_regs #(.NCH(NCH), .AW(AW), .IDW(IDW), .IDSUP(IDSUP)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit),
    .ch_base(ch_base), .ch_mask(ch_mask), .ch_id(ch_id),
    .ch_ctrl(ch_ctrl), .sts(hit_sts)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    ibrk_cmp #(.AW(AW), .IDW(IDW), .IDSUP(IDSUP)) u_cmp (
      .pc(ret_pc), .base(ch_base[c]), .mask(ch_mask[c]),
      .id_now(cur_id), .id_ch(ch_id[c]), .use_id(ch_ctrl[c][CB_USEID]),
      .match(cmp_hit[c])
    );
    assign be[c]  = ch_ctrl[c][CB_BRK];
    assign te[c]  = ch_ctrl[c][CB_TRG];
    assign hit[c] = eval && cmp_hit[c] && (be[c] || te[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
      trig    <= '0;
    end else begin
      brk_req <= |(hit & be);
      trig    <= hit & te;
    end
  end

  AST_NO_DEBUG_HIT: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |=> (!brk_req && trig == '0)); // R1
  AST_NO_SPEC_HIT: assert property (@(posedge clk) disable iff (rst)
    spec |=> (!brk_req && trig == '0)); // R2
  AST_BRK_HAS_STS: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (hit_sts != '0)); // R3
  AST_TRIG_HAS_STS: assert property (@(posedge clk) disable iff (rst)
    ((trig & hit_sts) == trig)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> (!brk_req && trig == '0)); // R10
endmodule

// File: tb/sim_ibrk_unit.sv
`timescale 1ns/1ps
module sim_ibrk_unit;
  localparam int NCH = 3;
  localparam int IDW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        ret_valid = 1'b0, dbg_mode = 1'b0, spec = 1'b0;
  logic [31:0] ret_pc = '0;
  logic [IDW-1:0] cur_id = '0;
  logic [31:0] rd0, rd1;
  logic        brk0, brk1;
  logic [NCH-1:0] trg0, sts0;
  logic [0:0]  trg1, sts1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ibrk_unit #(.NCH(NCH), .AW(32), .IDW(IDW), .IDSUP(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .cur_id(cur_id), .dbg_mode(dbg_mode), .spec(spec),
    .brk_req(brk0), .trig(trg0), .hit_sts(sts0));

  ibrk_unit #(.NCH(1), .AW(32), .IDW(IDW), .IDSUP(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .cur_id(cur_id), .dbg_mode(dbg_mode), .spec(spec),
    .brk_req(brk1), .trig(trg1), .hit_sts(sts1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); bus_addr = a;
    @(negedge clk);
  endtask

  task automatic retire(input logic v, input logic [31:0] pc, input logic [IDW-1:0] id,
                        input logic dm, input logic sp);
    @(negedge clk); ret_valid = v; ret_pc = pc; cur_id = id; dbg_mode = dm; spec = sp;
    @(negedge clk); ret_valid = 1'b0; dbg_mode = 1'b0; spec = 1'b0;
  endtask

  function automatic logic [5:0] ra(input int ch, input int fld);
    return 6'((ch << 2) | fld);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11 brk", 32'(brk0), 0);
    check("R11 trig", 32'(trg0), 0);
    check("R11 sts", 32'(sts0), 0);
    rd(ra(1, 0)); check("R11 base reg", rd0, 0);
    // R9: capability and readback
    rd(6'h21); check("R9 cap u0", rd0, 32'h13); check("R9 cap u1", rd1, 32'h01);
    wr(ra(1, 0), 32'h1234_5678);
    rd(ra(1, 0)); check("R9 readback", rd0, 32'h1234_5678);
    wr(ra(2, 1), 32'h00FF_0000);
    rd(ra(2, 1)); check("R9 mask readback", rd0, 32'h00FF_0000);
    wr(ra(5, 0), 32'hDEAD_BEEF);
    rd(ra(1, 0)); check("R9 out-of-range write", rd0, 32'h1234_5678);
    wr(ra(0, 2), 32'h5);
    rd(ra(0, 2)); check("R6 id reads zero u1", rd1, 0); check("R9 id readback", rd0, 5);

    // channel 0: base 0x1000, mask 0xF, break+trigger
    wr(ra(0, 0), 32'h1000); wr(ra(0, 1), 32'hF); wr(ra(0, 3), 32'h3);
    // channel 1: base 0x1003, no enables
    wr(ra(1, 0), 32'h1003); wr(ra(1, 1), 0); wr(ra(1, 3), 0);
    // R5 R3 R4: address sweep across the masked window
    for (int p = 'h0FF0; p < 'h1030; p++) begin
      logic e;
      e = ((p & ~32'hF) == 32'h1000);
      retire(1'b1, 32'(p), 0, 1'b0, 1'b0);
      check("R5 R3 brk sweep", 32'(brk0), 32'(e));
      check("R4 trig sweep", 32'(trg0), 32'(e));
      check("R5 u1 brk sweep", 32'(brk1), 32'(e));
    end
    rd(6'h20); check("R10 disabled channel sts", rd0, 32'h1);
    // R1 R2 R10: suppression
    wr(6'h20, 32'h7);
    retire(1'b1, 32'h1004, 0, 1'b1, 1'b0);
    check("R1 brk in debug", 32'(brk0), 0); check("R1 trig in debug", 32'(trg0), 0);
    retire(1'b1, 32'h1004, 0, 1'b0, 1'b1);
    check("R2 brk spec", 32'(brk0), 0); check("R2 trig spec", 32'(trg0), 0);
    retire(1'b0, 32'h1004, 0, 1'b0, 1'b0);
    check("R10 no valid", 32'(brk0), 0);
    rd(6'h20); check("R1 R2 R10 sts untouched", rd0, 0);

    // R4: trigger only channel; R8 simultaneous hits
    wr(ra(1, 0), 32'h1000); wr(ra(1, 1), 32'hF); wr(ra(1, 3), 32'h2);
    retire(1'b1, 32'h1005, 0, 1'b0, 1'b0);
    check("R8 trig both", 32'(trg0), 32'h3); check("R3 brk or", 32'(brk0), 1);
    rd(6'h20); check("R8 sts both", rd0, 32'h3);
    wr(ra(0, 3), 0);
    retire(1'b1, 32'h1005, 0, 1'b0, 1'b0);
    check("R4 trig only no brk", 32'(brk0), 0); check("R4 trig only", 32'(trg0), 32'h2);
    // R7: write-1-clear and set priority
    wr(6'h20, 32'h2);
    rd(6'h20); check("R7 clear bit1", rd0, 32'h1);
    @(negedge clk); bus_we = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h3;
    ret_valid = 1'b1; ret_pc = 32'h1001;
    @(negedge clk); bus_we = 1'b0; ret_valid = 1'b0;
    rd(6'h20); check("R7 set wins over clear", rd0, 32'h2);

    // R6: identifier sweep on channel 2
    wr(ra(1, 3), 0); wr(6'h20, 32'h7);
    wr(ra(2, 0), 32'h3000); wr(ra(2, 1), 0); wr(ra(2, 2), 32'h9); wr(ra(2, 3), 32'h7);
    for (int i = 0; i < 16; i++) begin
      retire(1'b1, 32'h3000, 4'(i), 1'b0, 1'b0);
      check("R6 id sweep brk", 32'(brk0), 32'(i == 9));
      check("R6 id sweep trig", 32'(trg0), (i == 9) ? 32'h4 : 32'h0);
    end
    // R6: id-use bit ignored without support (u1), honoured with support (u0)
    wr(ra(0, 3), 32'h5);
    retire(1'b1, 32'h1000, 4'd3, 1'b0, 1'b0);
    check("R6 u1 ignores id", 32'(brk1), 1);
    check("R6 u0 id mismatch", 32'(brk0), 0);
    retire(1'b1, 32'h1000, 4'd5, 1'b0, 1'b0);
    check("R6 u0 id match", 32'(brk0), 1);
    check("R3 pulse ends", 32'(brk0), 1);
    @(negedge clk); check("R3 one cycle", 32'(brk0), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule